// File: doc/BRIEF.md
# Cascaded Match and Full Flag Unit

Several content-addressable memory devices can be stacked into one longer table by linking them in a chain. This unit is the per-device flag logic for that chain. It takes the local compare results from the memory core: whether there was a hit, whether there was more than one hit, and whether any entry is still empty. It merges them with the match and full signals coming from the device above. It then drives the chained match and full signals on to the device below. All chain signals are active low.

The unit also elects the one device that answers an operation aimed at the highest-priority hit, and the one device that holds the next free entry. No external priority encoder is needed for either. A device-select value is compared with the device's own page address. A matching value addresses that one device, and an all-ones value addresses every device.

When the active configuration set is switched, the stored match results are cleared. Every output is registered, so a change ripples down the chain at one clock per device.

Top module: `cascade_flags`

## Requirements
- R1: When the chain is enabled and `match_flag_en`=1, `match_out_n` is 0 exactly when the stored local hit is set or `match_in_n` is 0. It reflects a compare two clocks after `cmp_done` is driven.
- R2: `chain_en_n` is captured only when `cyc_start`=1. If it is captured high, `match_out_n` is 1 from the second clock onward, whatever the local hit and `match_in_n` are.
- R3: When the chain is enabled and `match_flag_en`=0, `match_out_n` follows `match_in_n`, and the device elects no highest-priority responder.
- R4: When `full_flag_en`=1, `full_out_n` is 0 exactly when the stored no-free result is set and `full_in_n` is 0. When `full_flag_en`=0, `full_out_n` follows `full_in_n` one clock later.
- R5: `dev_match_n` and `dev_multi_n` are the inverted stored local hit and multi-hit results. They appear two clocks after `cmp_done` and do not depend on the chain inputs or on the chain enable.
- R6: `nf_resp` is 1 exactly when `full_in_n` is 0 and this device's `full_out_n` is 1. The first device has `full_in_n` tied 0 and `match_in_n` tied 1.
- R7: `hpm_resp` is 1 when the stored hit is set, `match_in_n` is 1 and `match_flag_en` is 1. In a chain, exactly one device is elected when any device hits.
- R8: A device is selected when `dev_sel` equals `page_addr`, or when `dev_sel` is all ones. Access kind 0 (write) is granted to every selected device.
- R9: A one-clock `set_switch` clears the stored hit and multi-hit results. `dev_match_n` and `dev_multi_n` then read 1 and `hpm_resp` reads 0 two clocks later. The no-free result is kept.
- R10: Access kind 1 (read) is granted only to a selected device that is the highest-priority responder, so a read with no hit anywhere is refused. Kind 2 (read of the next-free register) goes to a selected next-free responder. Kind 3 goes to the highest-priority responder and kind 4 goes to the next-free responder, both regardless of select. Kinds 5 to 7 are never granted.
- R11: During reset, `match_out_n`, `full_out_n`, `dev_match_n` and `dev_multi_n` are 1, and `hpm_resp`, `nf_resp` and `grant` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | Bus cycle start; captures `chain_en_n` |
| chain_en_n | input | 1 | Chain enable, active low |
| cmp_done | input | 1 | Local compare result valid this clock |
| loc_hit | input | 1 | Local compare found at least one valid hit |
| loc_multi | input | 1 | Local compare found more than one hit |
| loc_nofree | input | 1 | No empty entry left locally |
| set_switch | input | 1 | Active configuration set switched; clears match state |
| match_flag_en | input | 1 | Control bit enabling the local match flag in the chain |
| full_flag_en | input | 1 | Control bit enabling the local full flag in the chain |
| match_in_n | input | 1 | Chained match from the device above, active low |
| full_in_n | input | 1 | Chained full from the device above, active low |
| page_addr | input | PAGE_W | This device's page address |
| dev_sel | input | PAGE_W | Device-select value; all ones addresses every device |
| acc_valid | input | 1 | Access request present |
| acc_kind | input | 3 | Access kind (0 write, 1 read, 2 next-free read, 3 highest-priority op, 4 next-free op) |
| match_out_n | output | 1 | Chained match to the device below, active low |
| full_out_n | output | 1 | Chained full to the device below, active low |
| dev_match_n | output | 1 | Local match, not qualified by the chain, active low |
| dev_multi_n | output | 1 | Local multiple match, not qualified by the chain, active low |
| hpm_resp | output | 1 | This device answers highest-priority-match operations |
| nf_resp | output | 1 | This device answers next-free operations |
| grant | output | 1 | This device answers the access presented on the previous clock |

## Verification
Compare results and set switches land in the stored state on the first edge and reach the flag outputs on the second. So the local flags are sampled two clocks after the stimulus. An access is answered on `grant` one clock after it is presented. In a chain of three, each device adds one clock of ripple. Queue entries for exact timing are therefore due at +1 or +2 clocks. Chain-wide results are due only after six clocks with the inputs held, so every check samples a settled value between clock edges.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [2:0] {
    ACC_WRITE   = 3'd0,
    ACC_READ    = 3'd1,
    ACC_READ_NF = 3'd2,
    ACC_HPM_OP  = 3'd3,
    ACC_NF_OP   = 3'd4
  } acc_kind_e;
endpackage

// File: rtl/cfc_local_state.sv
// Holds the latest local compare results and the captured chain enable.
module cfc_local_state (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic chain_en_n,
  input  logic cmp_done,
  input  logic loc_hit,
  input  logic loc_multi,
  input  logic loc_nofree,
  input  logic set_switch,
  output logic hit_q,
  output logic multi_q,
  output logic nofree_q,
  output logic chain_on_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q      <= 1'b0;
      multi_q    <= 1'b0;
      nofree_q   <= 1'b0;
      chain_on_q <= 1'b0;
    end else begin
      if (cyc_start)
        chain_on_q <= ~chain_en_n;
      if (set_switch) begin
        hit_q   <= 1'b0;
        multi_q <= 1'b0;
      end else if (cmp_done) begin
        hit_q   <= loc_hit;
        multi_q <= loc_multi;
      end
      if (cmp_done)
        nofree_q <= loc_nofree;
    end
  end
endmodule

// File: rtl/cfc_flag_combine.sv
// Merges local state with the chain inputs; all results registered.
module cfc_flag_combine (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic multi,
  input  logic nofree,
  input  logic chain_on,
  input  logic match_flag_en,
  input  logic full_flag_en,
  input  logic match_in_n,
  input  logic full_in_n,
  output logic match_out_n,
  output logic full_out_n,
  output logic dev_match_n,
  output logic dev_multi_n,
  output logic hpm_q,
  output logic nf_q
);
  logic mo_d, fo_d, nf_d, hpm_d;

  always_comb begin
    if (!chain_on)          mo_d = 1'b1;
    else if (match_flag_en) mo_d = ~(hit | ~match_in_n);
    else                    mo_d = match_in_n;
    fo_d  = full_flag_en ? ~(nofree & ~full_in_n) : full_in_n;
    nf_d  = ~full_in_n & fo_d;
    hpm_d = hit & match_in_n & match_flag_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_out_n <= 1'b1;
      full_out_n  <= 1'b1;
      dev_match_n <= 1'b1;
      dev_multi_n <= 1'b1;
      hpm_q       <= 1'b0;
      nf_q        <= 1'b0;
    end else begin
      match_out_n <= mo_d;
      full_out_n  <= fo_d;
      dev_match_n <= ~hit;
      dev_multi_n <= ~multi;
      hpm_q       <= hpm_d;
      nf_q        <= nf_d;
    end
  end
endmodule

// File: rtl/cfc_dev_select.sv
// Page-address compare; BCAST_EN picks whether all ones addresses everyone.
module cfc_dev_select #(
  parameter int PAGE_W   = 4,
  parameter bit BCAST_EN = 1'b1
) (
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [PAGE_W-1:0] dev_sel,
  output logic              sel
);
  logic own_hit;
  assign own_hit = (dev_sel == page_addr);

  generate
    if (BCAST_EN) begin : g_bcast
      assign sel = own_hit | (&dev_sel);
    end else begin : g_single
      assign sel = own_hit;
    end
  endgenerate
endmodule

// File: rtl/cfc_grant.sv
// Decides whether this device answers the presented access.
module cfc_grant
  import cfc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      acc_valid,
  input  acc_kind_e acc_kind,
  input  logic      sel,
  input  logic      hpm,
  input  logic      nf,
  output logic      grant
);
  logic grant_d;

  always_comb begin
    unique case (acc_kind)
      ACC_WRITE:   grant_d = sel;
      ACC_READ:    grant_d = sel & hpm;
      ACC_READ_NF: grant_d = sel & nf;
      ACC_HPM_OP:  grant_d = hpm;
      ACC_NF_OP:   grant_d = nf;
      default:     grant_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) grant <= 1'b0;
    else     grant <= acc_valid & grant_d;
  end
endmodule

// File: rtl/cascade_flags.sv
module cascade_flags
  import cfc_pkg::*;
#(
  parameter int PAGE_W   = 4,
  parameter bit BCAST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic              chain_en_n,
  input  logic              cmp_done,
  input  logic              loc_hit,
  input  logic              loc_multi,
  input  logic              loc_nofree,
  input  logic              set_switch,
  input  logic              match_flag_en,
  input  logic              full_flag_en,
  input  logic              match_in_n,
  input  logic              full_in_n,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [PAGE_W-1:0] dev_sel,
  input  logic              acc_valid,
  input  logic [2:0]        acc_kind,
  output logic              match_out_n,
  output logic              full_out_n,
  output logic              dev_match_n,
  output logic              dev_multi_n,
  output logic              hpm_resp,
  output logic              nf_resp,
  output logic              grant
);
  logic hit_q, multi_q, nofree_q, chain_on_q, sel;

  cfc_local_state u_state (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .chain_en_n(chain_en_n),
    .cmp_done(cmp_done), .loc_hit(loc_hit), .loc_multi(loc_multi),
    .loc_nofree(loc_nofree), .set_switch(set_switch),
    .hit_q(hit_q), .multi_q(multi_q), .nofree_q(nofree_q), .chain_on_q(chain_on_q)
  );

  cfc_flag_combine u_comb (
    .clk(clk), .rst(rst), .hit(hit_q), .multi(multi_q), .nofree(nofree_q),
    .chain_on(chain_on_q), .match_flag_en(match_flag_en), .full_flag_en(full_flag_en),
    .match_in_n(match_in_n), .full_in_n(full_in_n),
    .match_out_n(match_out_n), .full_out_n(full_out_n),
    .dev_match_n(dev_match_n), .dev_multi_n(dev_multi_n),
    .hpm_q(hpm_resp), .nf_q(nf_resp)
  );

  cfc_dev_select #(.PAGE_W(PAGE_W), .BCAST_EN(BCAST_EN)) u_sel (
    .page_addr(page_addr), .dev_sel(dev_sel), .sel(sel)
  );

  cfc_grant u_grant (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind_e'(acc_kind)),
    .sel(sel), .hpm(hpm_resp), .nf(nf_resp), .grant(grant)
  );
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
  parameter int PAGE_W   = 4,
  parameter bit BCAST_EN = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_start,
  input logic              chain_en_n,
  input logic              cmp_done,
  input logic              loc_hit,
  input logic              set_switch,
  input logic              full_flag_en,
  input logic              full_in_n,
  input logic [PAGE_W-1:0] dev_sel,
  input logic              acc_valid,
  input logic [2:0]        acc_kind,
  input logic              match_out_n,
  input logic              full_out_n,
  input logic              dev_match_n,
  input logic              dev_multi_n,
  input logic              hpm_resp,
  input logic              nf_resp,
  input logic              grant
);
  AST_CHAIN_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && chain_en_n) |=> ##1 match_out_n); // R2

  AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
    !full_flag_en |=> (full_out_n == $past(full_in_n))); // R4

  AST_DEV_MATCH_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && !set_switch) ##1 (!cmp_done && !set_switch)
      |=> (dev_match_n == !$past(loc_hit, 2))); // R5

  AST_NF_ELECTION: assert property (@(posedge clk) disable iff (rst)
    nf_resp |-> (full_out_n && !$past(full_in_n))); // R6

  AST_HPM_HAS_HIT: assert property (@(posedge clk) disable iff (rst)
    hpm_resp |-> !dev_match_n); // R7

  AST_BCAST_WRITE: assert property (@(posedge clk) disable iff (rst)
    (BCAST_EN && acc_valid && acc_kind == 3'd0 && (&dev_sel)) |=> grant); // R8

  AST_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    set_switch ##1 !cmp_done |=> (dev_match_n && dev_multi_n && !hpm_resp)); // R9

  AST_READ_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 3'd1 && !hpm_resp) |=> !grant); // R10
endmodule

bind cascade_flags cfc_checker #(.PAGE_W(PAGE_W), .BCAST_EN(BCAST_EN)) u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .chain_en_n(chain_en_n),
  .cmp_done(cmp_done), .loc_hit(loc_hit), .set_switch(set_switch),
  .full_flag_en(full_flag_en), .full_in_n(full_in_n), .dev_sel(dev_sel),
  .acc_valid(acc_valid), .acc_kind(acc_kind), .match_out_n(match_out_n),
  .full_out_n(full_out_n), .dev_match_n(dev_match_n), .dev_multi_n(dev_multi_n),
  .hpm_resp(hpm_resp), .nf_resp(nf_resp), .grant(grant)
);

// File: tb/tb_cascade_flags.sv
module tb_cascade_flags;
  localparam int PW = 4;
  localparam int K_MO = 0, K_FO = 1, K_DM = 2, K_DX = 3, K_HPM = 4, K_NF = 5, K_GR = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic cyc_start = 0, chain_en_n = 1, cmp_done = 0, set_switch = 0;
  logic match_flag_en = 1, full_flag_en = 1, acc_valid = 0;
  logic [2:0] acc_kind = 3'd0;
  logic [PW-1:0] dev_sel = '1;
  logic loc_hit [3];
  logic loc_multi [3];
  logic loc_nofree [3];
  logic mo_n [3];
  logic fo_n [3];
  logic dm_n [3];
  logic dx_n [3];
  logic hpm [3];
  logic nf [3];
  logic gr [3];

  cascade_flags #(.PAGE_W(PW)) dut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .chain_en_n(chain_en_n),
    .cmp_done(cmp_done), .loc_hit(loc_hit[0]), .loc_multi(loc_multi[0]),
    .loc_nofree(loc_nofree[0]), .set_switch(set_switch),
    .match_flag_en(match_flag_en), .full_flag_en(full_flag_en),
    .match_in_n(1'b1), .full_in_n(1'b0), .page_addr(4'd0), .dev_sel(dev_sel),
    .acc_valid(acc_valid), .acc_kind(acc_kind),
    .match_out_n(mo_n[0]), .full_out_n(fo_n[0]), .dev_match_n(dm_n[0]),
    .dev_multi_n(dx_n[0]), .hpm_resp(hpm[0]), .nf_resp(nf[0]), .grant(gr[0]));

  cascade_flags #(.PAGE_W(PW)) dut_mid (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .chain_en_n(chain_en_n),
    .cmp_done(cmp_done), .loc_hit(loc_hit[1]), .loc_multi(loc_multi[1]),
    .loc_nofree(loc_nofree[1]), .set_switch(set_switch),
    .match_flag_en(match_flag_en), .full_flag_en(full_flag_en),
    .match_in_n(mo_n[0]), .full_in_n(fo_n[0]), .page_addr(4'd1), .dev_sel(dev_sel),
    .acc_valid(acc_valid), .acc_kind(acc_kind),
    .match_out_n(mo_n[1]), .full_out_n(fo_n[1]), .dev_match_n(dm_n[1]),
    .dev_multi_n(dx_n[1]), .hpm_resp(hpm[1]), .nf_resp(nf[1]), .grant(gr[1]));

  cascade_flags #(.PAGE_W(PW)) dut_last (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .chain_en_n(chain_en_n),
    .cmp_done(cmp_done), .loc_hit(loc_hit[2]), .loc_multi(loc_multi[2]),
    .loc_nofree(loc_nofree[2]), .set_switch(set_switch),
    .match_flag_en(match_flag_en), .full_flag_en(full_flag_en),
    .match_in_n(mo_n[1]), .full_in_n(fo_n[1]), .page_addr(4'd2), .dev_sel(dev_sel),
    .acc_valid(acc_valid), .acc_kind(acc_kind),
    .match_out_n(mo_n[2]), .full_out_n(fo_n[2]), .dev_match_n(dm_n[2]),
    .dev_multi_n(dx_n[2]), .hpm_resp(hpm[2]), .nf_resp(nf[2]), .grant(gr[2]));

  typedef struct {
    int    due;
    int    dev;
    int    kind;
    logic  exp;
    string tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic get_sig(int d, int k);
    case (k)
      K_MO:    return mo_n[d];
      K_FO:    return fo_n[d];
      K_DM:    return dm_n[d];
      K_DX:    return dx_n[d];
      K_HPM:   return hpm[d];
      K_NF:    return nf[d];
      default: return gr[d];
    endcase
  endfunction

  // Monitor: pops every item due at this falling edge and compares it.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic act;
        act = get_sig(sb[i].dev, sb[i].kind);
        total++;
        if (act !== sb[i].exp) begin
          bad++;
          $display("FAIL %s dev%0d sig%0d actual=%b expected=%b",
                   sb[i].tag, sb[i].dev, sb[i].kind, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(int dly, int d, int k, logic v, string tag);
    item_t it;
    it.due = cyc + dly; it.dev = d; it.kind = k; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp3(int k, logic a, logic b, logic c, string tag);
    expect_at(6, 0, k, a, tag);
    expect_at(6, 1, k, b, tag);
    expect_at(6, 2, k, c, tag);
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_loc(logic h0, logic h1, logic h2, logic m2, logic f0, logic f1, logic f2);
    loc_hit[0] = h0; loc_hit[1] = h1; loc_hit[2] = h2;
    loc_multi[0] = 1'b0; loc_multi[1] = 1'b0; loc_multi[2] = m2;
    loc_nofree[0] = f0; loc_nofree[1] = f1; loc_nofree[2] = f2;
  endtask

  task automatic pulse_cmp();
    cmp_done = 1'b1;
    run(1);
    cmp_done = 1'b0;
  endtask

  task automatic access(logic [2:0] kind, logic [PW-1:0] s,
                        logic g0, logic g1, logic g2, string tag);
    acc_valid = 1'b1; acc_kind = kind; dev_sel = s;
    expect_at(1, 0, K_GR, g0, tag);
    expect_at(1, 1, K_GR, g1, tag);
    expect_at(1, 2, K_GR, g2, tag);
    run(1);
    acc_valid = 1'b0; dev_sel = '1;
    run(1);
  endtask

  initial begin
    set_loc(0, 0, 0, 0, 0, 0, 0);
    run(2);
    // R11 reset state, observed while reset is held
    for (int d = 0; d < 3; d++) begin
      expect_at(1, d, K_MO, 1'b1, "R11");
      expect_at(1, d, K_FO, 1'b1, "R11");
      expect_at(1, d, K_DM, 1'b1, "R11");
      expect_at(1, d, K_DX, 1'b1, "R11");
      expect_at(1, d, K_HPM, 1'b0, "R11");
      expect_at(1, d, K_NF, 1'b0, "R11");
      expect_at(1, d, K_GR, 1'b0, "R11");
    end
    run(1);
    rst = 1'b0;
    run(2);

    // R1 R5 timing: hits in mid and last, multi in last, chain enabled
    set_loc(0, 1, 1, 1, 0, 0, 0);
    cyc_start = 1'b1; chain_en_n = 1'b0; cmp_done = 1'b1;
    expect_at(1, 1, K_DM, 1'b1, "R5 not before 2 clocks");
    expect_at(2, 1, K_DM, 1'b0, "R5 due at 2 clocks");
    expect_at(2, 1, K_MO, 1'b0, "R1 due at 2 clocks");
    run(1);
    cyc_start = 1'b0; chain_en_n = 1'b1; cmp_done = 1'b0;
    exp3(K_MO, 1, 0, 0, "R1 chained match");
    exp3(K_DM, 1, 0, 0, "R5 local match");
    exp3(K_DX, 1, 1, 0, "R5 local multi");
    exp3(K_HPM, 0, 1, 0, "R7 one responder");
    exp3(K_NF, 1, 0, 0, "R6 first free");
    run(7);

    // R7 R8 R10 access routing
    access(3'd3, 4'hF, 0, 1, 0, "R7 hpm op");
    access(3'd1, 4'hF, 0, 1, 0, "R10 read to hpm");
    access(3'd1, 4'h0, 0, 0, 0, "R10 read unselected");
    access(3'd0, 4'h2, 0, 0, 1, "R8 write one device");
    access(3'd0, 4'hF, 1, 1, 1, "R8 write broadcast");
    access(3'd0, 4'h5, 0, 0, 0, "R8 write no device");
    access(3'd4, 4'h0, 1, 0, 0, "R10 nf op");
    access(3'd2, 4'hF, 1, 0, 0, "R10 nf read");
    access(3'd6, 4'hF, 0, 0, 0, "R10 unused kind");

    // R4 R6 full chain: first and last have no free entry
    set_loc(0, 1, 1, 1, 1, 0, 1);
    pulse_cmp();
    exp3(K_FO, 0, 1, 1, "R4 full combine");
    exp3(K_NF, 0, 1, 0, "R6 nf moves down");
    run(7);
    access(3'd2, 4'hF, 0, 1, 0, "R10 nf read mid");
    set_loc(0, 1, 1, 1, 1, 1, 1);
    pulse_cmp();
    exp3(K_FO, 0, 0, 0, "R4 system full");
    exp3(K_NF, 0, 0, 0, "R6 no free anywhere");
    run(7);

    // R4 full flag disabled: outputs follow full inputs
    set_loc(0, 1, 1, 1, 0, 0, 0);
    full_flag_en = 1'b0;
    pulse_cmp();
    exp3(K_FO, 0, 0, 0, "R4 pass-through");
    exp3(K_NF, 0, 0, 0, "R6 pass-through");
    run(7);
    full_flag_en = 1'b1;

    // R3 match flag disabled
    match_flag_en = 1'b0;
    exp3(K_MO, 1, 1, 1, "R3 follows match in");
    exp3(K_DM, 1, 0, 0, "R5 unaffected by flag enable");
    exp3(K_HPM, 0, 0, 0, "R3 no election");
    run(7);
    match_flag_en = 1'b1;

    // R7 all three hit: only the first is elected
    set_loc(1, 1, 1, 1, 0, 0, 0);
    pulse_cmp();
    exp3(K_HPM, 1, 0, 0, "R7 topmost wins");
    exp3(K_MO, 0, 0, 0, "R1 all low");
    exp3(K_NF, 1, 0, 0, "R6 first free");
    run(7);

    // R2 chain disabled by a cycle with enable high
    cyc_start = 1'b1; chain_en_n = 1'b1;
    expect_at(1, 0, K_MO, 1'b0, "R2 not before 2 clocks");
    expect_at(2, 0, K_MO, 1'b1, "R2 due at 2 clocks");
    run(1);
    cyc_start = 1'b0;
    chain_en_n = 1'b0;
    exp3(K_MO, 1, 1, 1, "R2 held inactive");
    exp3(K_DM, 0, 0, 0, "R5 not qualified by chain");
    run(7);

    // R9 set switch clears match state, keeps full state
    cyc_start = 1'b1; chain_en_n = 1'b0;
    run(1);
    cyc_start = 1'b0; chain_en_n = 1'b1;
    run(4);
    set_switch = 1'b1;
    expect_at(1, 1, K_DM, 1'b0, "R9 not before 2 clocks");
    expect_at(2, 1, K_DM, 1'b1, "R9 due at 2 clocks");
    run(1);
    set_switch = 1'b0;
    exp3(K_DM, 1, 1, 1, "R9 match cleared");
    exp3(K_DX, 1, 1, 1, "R9 multi cleared");
    exp3(K_HPM, 0, 0, 0, "R9 no responder");
    exp3(K_MO, 1, 1, 1, "R9 chain match cleared");
    exp3(K_NF, 1, 0, 0, "R9 free state kept");
    run(7);
    access(3'd1, 4'hF, 0, 0, 0, "R10 read refused no match");
    access(3'd2, 4'hF, 1, 0, 0, "R10 nf read still allowed");

    run(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule